// File: doc/BRIEF.md
# Word-Pair DWORD Read Coherency Unit

This unit sits between a serial management port that moves 16-bit words and a small bank of 32-bit control and status registers. A host reads each 32-bit register as two 16-bit words. It names a register index and picks the upper or lower half. On the first word of a pair the unit captures the whole 32-bit value and returns the requested half. The partner word then comes from that capture, so the two halves always belong to the same instant. This holds even when a live field such as a counter crosses the 16-bit boundary between the two reads.

Read side effects are tied to the second word. Sticky event bits are cleared and a receive FIFO is popped as soon as the second word begins. A host that abandons the shift partway still gets the side effect. Hardware events that arrive between the capture and the clear are parked in a one-bit-per-event pending store and merged back after the clear, so none is lost. One register holds a FIFO fill level and a constant identifier. It may be read one word at a time and never disturbs the pairing. A write access drops any half-finished pair. A flag reports whether the last pair completed with opposite halves.

The bank holds four registers:

| Index | Name | Content |
|---|---|---|
| 0 | event counter | 32-bit counter that increments once per cycle while `cnt_inc` is high |
| 1 | sticky events | clear-on-read sticky event bits in `[NEV-1:0]`; other bits read zero |
| 2 | FIFO head | oldest FIFO entry, or zero when the FIFO is empty |
| 3 | word-wide info | bits `[15:0]` hold the FIFO fill level and bits `[31:16]` hold the `ID` parameter |

Indices 4 to 7 are unused.

Top module: `coh_dword_read`

## Requirements
- R1: After synchronous reset, `rd_word` and `pair_valid` are 0, no pair is open, the sticky event bits are clear, and the FIFO is empty, so index 3 low reads 0.
- R2: A read that opens a pair captures the full 32-bit value of the addressed register in the cycle `rd_req` is sampled. The half named by `rd_hi` appears on `rd_word` the next cycle: `rd_hi`=1 gives bits [31:16] and 0 gives bits [15:0].
- R3: The second word of a pair is taken from the capture, not from the register's current value. A counter that moves between the two reads still yields a coherent 32-bit value.
- R4: The halves may be read in either order, upper-then-lower or lower-then-upper.
- R5: Reading the same half twice in a row abandons the open pair without error. `pair_valid` goes to 0, and the repeated read opens a new pair with a fresh capture.
- R6: `pair_valid` becomes 1 one cycle after `rd_done` ends an opposite-half second word. It returns to 0 when the next paired read starts.
- R7: Index 3 is word-wide. Each half is returned live as a single read and leaves the pairing state untouched, so an open pair can still be completed after it.
- R8: Index 1 holds sticky event bits in [NEV-1:0]; an event pulse on `hw_evt[i]` sets bit i. The bits are cleared when the second word of a pair opened on index 1 starts. The clear happens even if `rd_done` for that word never comes.
- R9: An event that arrives after the capture but before the clear is kept and reads back as set after the clear. Several such events merge into one set bit.
- R10: Index 2 returns the FIFO head, or 0 when the FIFO is empty. The FIFO pops once when the second word of a pair opened on index 2 starts, even if that word is abandoned.
- R11: The second word's index is not checked. The data comes from the first word's capture and the side effect goes to the first word's register.
- R12: A write access (`wr_req`) closes any open pair and clears `pair_valid`, so the next paired read opens a fresh pair.
- R13: Unused indices 4 to 7 read as zero and pair like normal registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| rd_req | input | 1 | start of a word read, one cycle |
| rd_addr | input | AW | register index |
| rd_hi | input | 1 | 1 = upper half, 0 = lower half |
| rd_done | input | 1 | the current word's shift has finished |
| wr_req | input | 1 | a write access is taking place |
| cnt_inc | input | 1 | increments the event counter (index 0) |
| hw_evt | input | NEV | event pulses into the sticky bits of index 1 |
| fifo_push | input | 1 | pushes `fifo_wdata` into the FIFO |
| fifo_wdata | input | 32 | FIFO entry data |
| rd_word | output | 16 | returned word, valid the cycle after `rd_req` |
| pair_valid | output | 1 | the last pair completed with opposite halves |

## Verification
Some properties are checked on every cycle:
- `pair_valid` only rises after a `rd_done` and is only high with no pair open.
- A same-half repeat reopens a pair.
- A word-wide read leaves the tracker alone.
- No event pulse ever vanishes from the sticky bits and the pending store.
- After a clear, only parked or fresh events remain.
- The FIFO level stays bounded and drops by one on a pop.

Other behaviours only the directed scenarios can show:
- The coherence of the two halves across the counter's 16-bit carry.
- Both read orders.
- The abandoned-shift side effects.
- Unchecked second-word indices.
- Write-induced reopening.
- The exact data returned.

// File: rtl/coh_pkg.sv
package coh_pkg;

    localparam int unsigned REG_CNT  = 0;
    localparam int unsigned REG_STAT = 1;
    localparam int unsigned REG_FIFO = 2;
    localparam int unsigned REG_INFO = 3;

    typedef enum logic [1:0] {
        TRK_IDLE  = 2'd0,
        TRK_HAVE1 = 2'd1,
        TRK_HAVE2 = 2'd2
    } trk_state_e;

    typedef struct packed {
        logic [31:0] data;
        logic        hi_first;
    } snap_t;

    function automatic logic [15:0] half_of(input logic [31:0] v, input logic hi);
        return hi ? v[31:16] : v[15:0];
    endfunction

endpackage

// File: rtl/coh_pair_track.sv
module coh_pair_track
    import coh_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    input  logic          rd_hi,
    input  logic          rd_done,
    input  logic          wr_req,
    input  logic          word_wide,
    input  logic [31:0]   bank_val,
    output logic [15:0]   rd_word,
    output logic          pair_valid,
    output logic          first_start,
    output logic          second_start,
    output logic          have1,
    output logic [AW-1:0] snap_addr
);

    trk_state_e state;
    snap_t      snap;
    logic       paired_req;

    assign paired_req   = rd_req && !word_wide && !wr_req;
    assign second_start = paired_req && (state == TRK_HAVE1) && (rd_hi != snap.hi_first);
    assign first_start  = paired_req && !second_start;
    assign have1        = (state == TRK_HAVE1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= TRK_IDLE;
            snap       <= '0;
            snap_addr  <= '0;
            rd_word    <= '0;
            pair_valid <= 1'b0;
        end else begin
            if (rd_req) begin
                rd_word <= second_start ? half_of(snap.data, rd_hi)
                                        : half_of(bank_val, rd_hi);
            end
            if (wr_req) begin
                state      <= TRK_IDLE;
                pair_valid <= 1'b0;
            end else if (first_start) begin
                snap       <= '{data: bank_val, hi_first: rd_hi};
                snap_addr  <= rd_addr;
                state      <= TRK_HAVE1;
                pair_valid <= 1'b0;
            end else if (second_start) begin
                state      <= TRK_HAVE2;
                pair_valid <= 1'b0;
            end else if (rd_done && state == TRK_HAVE2) begin
                state      <= TRK_IDLE;
                pair_valid <= 1'b1;
            end
        end
    end

    // R6: completion flag only follows an end-of-word strobe
    a_r6_valid_after_done: assert property (@(posedge clk) disable iff (rst)
        $rose(pair_valid) |-> $past(rd_done));

    // R6: a valid pair means the tracker is waiting for a new first word
    a_r6_valid_idle: assert property (@(posedge clk) disable iff (rst)
        pair_valid |-> (state == TRK_IDLE));

    // R5: a same-half repeat reopens a pair and drops the flag
    a_r5_repeat_restarts: assert property (@(posedge clk) disable iff (rst)
        (paired_req && state == TRK_HAVE1 && rd_hi == snap.hi_first)
        |=> (state == TRK_HAVE1 && !pair_valid));

    // R7: a word-wide read leaves the tracker untouched
    a_r7_wide_no_effect: assert property (@(posedge clk) disable iff (rst)
        (rd_req && word_wide && !wr_req && !rd_done)
        |=> ($stable(state) && $stable(snap_addr) && $stable(pair_valid)));

endmodule

// File: rtl/coh_evt_reg.sv
module coh_evt_reg #(
    parameter int NEV = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NEV-1:0] evt,
    input  logic           hold,
    input  logic           clr,
    output logic [NEV-1:0] stat
);

    logic [NEV-1:0] pend;
    logic           started;

    for (genvar i = 0; i < NEV; i++) begin : g_bit
        logic s_q;
        logic p_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                s_q <= 1'b0;
                p_q <= 1'b0;
            end else if (clr) begin
                s_q <= p_q | evt[i];
                p_q <= 1'b0;
            end else if (hold) begin
                p_q <= p_q | evt[i];
            end else begin
                s_q <= s_q | p_q | evt[i];
                p_q <= 1'b0;
            end
        end
        assign stat[i] = s_q;
        assign pend[i] = p_q;
    end

    always_ff @(posedge clk) begin
        if (rst) started <= 1'b0;
        else     started <= 1'b1;
    end

    // R9: no event pulse disappears from the sticky or pending store
    a_r9_no_lost_event: assert property (@(posedge clk) disable iff (rst)
        started |-> (($past(evt) & ~(stat | pend)) == '0));

    // R8: after a clear only parked or fresh events remain
    a_r8_clear_leaves_new: assert property (@(posedge clk) disable iff (rst)
        clr |=> ((stat & ~$past(pend | evt)) == '0));

endmodule

// File: rtl/coh_fifo.sv
module coh_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [$clog2(DEPTH+1)-1:0] level
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign do_push = push && (level != LW'(DEPTH));
    assign do_pop  = pop && (level != '0);
    assign head    = (level == '0) ? '0 : mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R10: level never exceeds the depth
    a_r10_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH));

    // R10: a lone pop on a non-empty FIFO removes exactly one entry
    a_r10_pop_step: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && level != '0) |=> (level == $past(level) - 1'b1));

endmodule

// File: rtl/coh_dword_read.sv
module coh_dword_read
    import coh_pkg::*;
#(
    parameter int          AW     = 3,
    parameter int          NEV    = 4,
    parameter int          FDEPTH = 4,
    parameter logic [15:0] ID     = 16'hC0DE
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rd_req,
    input  logic [AW-1:0]  rd_addr,
    input  logic           rd_hi,
    input  logic           rd_done,
    input  logic           wr_req,
    input  logic           cnt_inc,
    input  logic [NEV-1:0] hw_evt,
    input  logic           fifo_push,
    input  logic [31:0]    fifo_wdata,
    output logic [15:0]    rd_word,
    output logic           pair_valid
);

    localparam int LW = $clog2(FDEPTH + 1);
    localparam logic [AW-1:0] A_CNT  = AW'(REG_CNT);
    localparam logic [AW-1:0] A_STAT = AW'(REG_STAT);
    localparam logic [AW-1:0] A_FIFO = AW'(REG_FIFO);
    localparam logic [AW-1:0] A_INFO = AW'(REG_INFO);

    logic [31:0]    cnt_q;
    logic [NEV-1:0] stat;
    logic [31:0]    fifo_head;
    logic [LW-1:0]  fifo_level;
    logic [31:0]    bank_val;
    logic           word_wide;
    logic           first_start, second_start, have1;
    logic [AW-1:0]  snap_addr;
    logic           stat_hold, stat_clr, fifo_pop;

    always_ff @(posedge clk) begin
        if (rst)          cnt_q <= '0;
        else if (cnt_inc) cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        case (rd_addr)
            A_CNT:   bank_val = cnt_q;
            A_STAT:  bank_val = 32'(stat);
            A_FIFO:  bank_val = fifo_head;
            A_INFO:  bank_val = {ID, 16'(fifo_level)};
            default: bank_val = '0;
        endcase
    end

    assign word_wide = (rd_addr == A_INFO);
    assign stat_clr  = second_start && (snap_addr == A_STAT);
    assign fifo_pop  = second_start && (snap_addr == A_FIFO);
    assign stat_hold = (have1 && snap_addr == A_STAT) ||
                       (first_start && rd_addr == A_STAT);

    coh_pair_track #(.AW(AW)) u_track (
        .clk          (clk),
        .rst          (rst),
        .rd_req       (rd_req),
        .rd_addr      (rd_addr),
        .rd_hi        (rd_hi),
        .rd_done      (rd_done),
        .wr_req       (wr_req),
        .word_wide    (word_wide),
        .bank_val     (bank_val),
        .rd_word      (rd_word),
        .pair_valid   (pair_valid),
        .first_start  (first_start),
        .second_start (second_start),
        .have1        (have1),
        .snap_addr    (snap_addr)
    );

    coh_evt_reg #(.NEV(NEV)) u_evt (
        .clk  (clk),
        .rst  (rst),
        .evt  (hw_evt),
        .hold (stat_hold),
        .clr  (stat_clr),
        .stat (stat)
    );

    coh_fifo #(.DEPTH(FDEPTH), .DW(32)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (fifo_push),
        .wdata (fifo_wdata),
        .pop   (fifo_pop),
        .head  (fifo_head),
        .level (fifo_level)
    );

    // R11: the side effect lands on the first word's register, whatever the second index
    a_r11_pop_on_snap: assert property (@(posedge clk) disable iff (rst)
        (second_start && snap_addr == A_FIFO && fifo_level != '0 && !fifo_push)
        |=> (fifo_level == $past(fifo_level) - 1'b1));

endmodule

// File: tb/coh_dword_read_bench.sv
module coh_dword_read_bench;

    localparam logic [15:0] ID = 16'hC0DE;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_req = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic        rd_hi = 1'b0;
    logic        rd_done = 1'b0;
    logic        wr_req = 1'b0;
    logic        cnt_inc = 1'b0;
    logic [3:0]  hw_evt = '0;
    logic        fifo_push = 1'b0;
    logic [31:0] fifo_wdata = '0;
    logic [15:0] rd_word;
    logic        pair_valid;

    int unsigned errors = 0;
    int unsigned checks = 0;
    logic [31:0] m;
    logic [31:0] cap;
    logic [15:0] w;
    logic        finished = 1'b0;

    always #5 clk = ~clk;

    coh_dword_read #(.AW(3), .NEV(4), .FDEPTH(4), .ID(ID)) u_coh_dword_read (
        .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr), .rd_hi(rd_hi),
        .rd_done(rd_done), .wr_req(wr_req), .cnt_inc(cnt_inc), .hw_evt(hw_evt),
        .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
        .rd_word(rd_word), .pair_valid(pair_valid)
    );

    // independent model of the event counter
    always @(posedge clk) begin
        if (rst)          m <= '0;
        else if (cnt_inc) m <= m + 1;
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, input logic hi, output logic [15:0] o);
        @(negedge clk);
        rd_req = 1'b1; rd_addr = a; rd_hi = hi; cap = m;
        @(negedge clk);
        rd_req = 1'b0;
        o = rd_word;
    endtask

    task automatic fin();
        @(negedge clk); rd_done = 1'b1;
        @(negedge clk); rd_done = 1'b0;
    endtask

    task automatic evt(input logic [3:0] v);
        @(negedge clk); hw_evt = v;
        @(negedge clk); hw_evt = '0;
    endtask

    task automatic push(input logic [31:0] d);
        @(negedge clk); fifo_push = 1'b1; fifo_wdata = d;
        @(negedge clk); fifo_push = 1'b0;
    endtask

    task automatic wr();
        @(negedge clk); wr_req = 1'b1;
        @(negedge clk); wr_req = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rd_word after reset", 32'(rd_word), 32'h0);
        chk("R1 pair_valid after reset", 32'(pair_valid), 32'h0);
        rd(3'd0, 1'b0, w); chk("R1 counter low after reset", 32'(w), 32'h0);
        rd(3'd3, 1'b0, w); chk("R1 FIFO level after reset", 32'(w), 32'h0);
        rd(3'd3, 1'b1, w); chk("R7 info high is ID", 32'(w), 32'(ID));
        wr();
    endtask

    task automatic t_lo_hi();
        logic [31:0] c;
        cnt_inc = 1'b1;
        repeat (65530) @(negedge clk);
        rd(3'd0, 1'b0, w); c = cap;
        chk("R2 counter low first word", 32'(w), 32'(c[15:0]));
        chk("R6 pair_valid low after first word", 32'(pair_valid), 32'h0);
        repeat (12) @(negedge clk);
        rd(3'd0, 1'b1, w);
        chk("R3 counter high from capture", 32'(w), 32'(c[31:16]));
        chk("R3 live counter moved past capture high", 32'(cap[31:16] != c[31:16]), 32'h1);
        fin();
        chk("R6 pair_valid after opposite pair", 32'(pair_valid), 32'h1);
    endtask

    task automatic t_hi_lo();
        logic [31:0] c;
        rd(3'd0, 1'b1, w); c = cap;
        chk("R4 high first", 32'(w), 32'(c[31:16]));
        rd(3'd0, 1'b0, w);
        chk("R4 low second from capture", 32'(w), 32'(c[15:0]));
        fin();
        chk("R4 pair_valid high-low order", 32'(pair_valid), 32'h1);
    endtask

    task automatic t_repeat();
        logic [31:0] c;
        rd(3'd0, 1'b0, w);
        repeat (3) @(negedge clk);
        rd(3'd0, 1'b0, w); c = cap;
        chk("R5 repeat gives fresh capture", 32'(w), 32'(c[15:0]));
        chk("R5 pair_valid low after repeat", 32'(pair_valid), 32'h0);
        rd(3'd0, 1'b1, w);
        chk("R5 new pair completes", 32'(w), 32'(c[31:16]));
        fin();
        chk("R5 pair_valid after restarted pair", 32'(pair_valid), 32'h1);
    endtask

    task automatic t_wide();
        logic [31:0] c;
        rd(3'd0, 1'b0, w); c = cap;
        rd(3'd3, 1'b1, w); chk("R7 single-word ID read", 32'(w), 32'(ID));
        rd(3'd3, 1'b0, w); chk("R7 single-word level read", 32'(w), 32'h0);
        rd(3'd0, 1'b1, w);
        chk("R7 open pair survives word-wide reads", 32'(w), 32'(c[31:16]));
        fin();
        chk("R7 pair_valid after interleaved wide reads", 32'(pair_valid), 32'h1);
        cnt_inc = 1'b0;
    endtask

    task automatic t_status();
        evt(4'h1);
        rd(3'd1, 1'b0, w); chk("R8 sticky bit0 seen", 32'(w), 32'h1);
        evt(4'h4);
        evt(4'h4);
        rd(3'd1, 1'b1, w); chk("R8 status high", 32'(w), 32'h0);
        fin();
        rd(3'd1, 1'b0, w); chk("R9 deferred event kept, bit0 cleared", 32'(w), 32'h4);
        rd(3'd1, 1'b1, w); fin();
        rd(3'd1, 1'b0, w); chk("R8 cleared after read", 32'(w), 32'h0);
        rd(3'd1, 1'b1, w); fin();
        evt(4'h2);
        rd(3'd1, 1'b0, w); chk("R8 bit1 seen", 32'(w), 32'h2);
        rd(3'd1, 1'b1, w);
        rd(3'd1, 1'b0, w); chk("R8 abandoned second word still clears", 32'(w), 32'h0);
        rd(3'd1, 1'b1, w); fin();
    endtask

    task automatic t_fifo();
        push(32'h1234_5678);
        push(32'h9ABC_DEF0);
        rd(3'd3, 1'b0, w); chk("R10 level two", 32'(w), 32'h2);
        rd(3'd2, 1'b1, w); chk("R10 head high", 32'(w), 32'h1234);
        rd(3'd2, 1'b0, w); chk("R10 head low", 32'(w), 32'h5678);
        fin();
        rd(3'd3, 1'b0, w); chk("R10 popped once", 32'(w), 32'h1);
        rd(3'd2, 1'b0, w); chk("R10 next head low", 32'(w), 32'hDEF0);
        rd(3'd2, 1'b1, w); chk("R10 next head high", 32'(w), 32'h9ABC);
        fin();
        rd(3'd3, 1'b0, w); chk("R10 empty level", 32'(w), 32'h0);
        rd(3'd2, 1'b0, w); chk("R10 empty reads zero", 32'(w), 32'h0);
        rd(3'd2, 1'b1, w); fin();
        push(32'h5555_AAAA);
        rd(3'd2, 1'b0, w);
        rd(3'd2, 1'b1, w);
        rd(3'd3, 1'b0, w); chk("R10 abandoned shift still pops", 32'(w), 32'h0);
    endtask

    task automatic t_cross();
        push(32'hCAFE_F00D);
        rd(3'd2, 1'b0, w); chk("R11 FIFO low first", 32'(w), 32'hF00D);
        rd(3'd0, 1'b1, w); chk("R11 second index ignored, data from capture", 32'(w), 32'hCAFE);
        fin();
        chk("R11 pair_valid with mismatched index", 32'(pair_valid), 32'h1);
        rd(3'd3, 1'b0, w); chk("R11 pop hit first word's FIFO", 32'(w), 32'h0);
    endtask

    task automatic t_write();
        wr();
        chk("R12 write clears pair_valid", 32'(pair_valid), 32'h0);
        evt(4'h1);
        rd(3'd1, 1'b0, w); chk("R12 status before write", 32'(w), 32'h1);
        wr();
        evt(4'h8);
        rd(3'd1, 1'b1, w); chk("R12 post-write read opens pair", 32'(w), 32'h0);
        rd(3'd1, 1'b0, w); chk("R12 fresh capture after write", 32'(w), 32'h9);
        fin();
        chk("R12 pair completes after write", 32'(pair_valid), 32'h1);
    endtask

    task automatic t_unused();
        rd(3'd5, 1'b0, w); chk("R13 unused low", 32'(w), 32'h0);
        rd(3'd5, 1'b1, w); chk("R13 unused high", 32'(w), 32'h0);
        fin();
        chk("R13 unused index pairs", 32'(pair_valid), 32'h1);
        rd(3'd7, 1'b1, w); chk("R13 top index", 32'(w), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_lo_hi();
        t_hi_lo();
        t_repeat();
        t_wide();
        t_status();
        t_fifo();
        t_cross();
        t_write();
        t_unused();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule